// File: doc/BRIEF.md
# Byte ALU with Packed Condition Flags

This block performs the 8-bit arithmetic and logic operations of a small accumulator-style processor and also forms a 16-bit stack-pointer sum with a signed byte offset. The datapath is purely combinational. An operation code picks the function. Two byte operands, the incoming flag byte and the 16-bit stack pointer feed it. It returns an 8-bit result, a 16-bit sum and a new flag byte in the same cycle.

A flag register sits beside the datapath. It captures the new flag byte on a clock edge when the caller marks the operation as valid. The register file, instruction sequencing and memory traffic belong to the surrounding core.

The flag byte packs four conditions into its upper nibble: zero (Z), subtract (N), half-carry (H) and carry (C). The decimal-adjust, add-with-carry and subtract-with-borrow operations read these flags back through `flags_in`.

Top module: `byte_alu_core`

## Requirements
- R1: The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3:0 of `flags_out` and `flag_q` are always zero, whatever `flags_in[3:0]` holds.
- R2: Add (code 0) and add-with-carry (code 1, carry-in = `flags_in[4]`) give result = (A+B+cin) mod 256 and N=0. H is set when A[3:0]+B[3:0]+cin ≥ 16, C when A+B+cin ≥ 256, and Z when the result is 0.
- R3: Subtract (code 2) and subtract-with-borrow (code 3, borrow-in = `flags_in[4]`) give result = (A−B−bin) mod 256 and N=1. H is set when A[3:0]−B[3:0]−bin < 0, C when A−B−bin < 0, and Z when the result is 0.
- R4: Compare (code 7) produces the flags of a code-2 subtract and returns A unchanged as the result.
- R5: AND (code 4), XOR (code 5) and OR (code 6) return the bitwise result. Each sets Z from it and clears N and C. H is 1 for AND and 0 for XOR and OR.
- R6: Increment (code 8) and decrement (code 9) act on A and keep C from `flags_in`. Increment sets H when A[3:0] was 0xF and clears N. Decrement sets H when A[3:0] was 0x0 and sets N. Z follows the result.
- R7: Decimal adjust (code 10) with N=0 in `flags_in` works in two steps. It first adds 0x06 when A[3:0] > 9 or H is set, giving a 9-bit intermediate t. It then adds 0x60 and sets C when t[8:4] > 9 or C was set; otherwise it clears C. N is kept, H is cleared and Z follows the result.
- R8: Decimal adjust with N=1 adds 0xFA when H is set and 0xA0 when C is set, modulo 256. It keeps C and N, clears H and sets Z from the result.
- R9: Set-carry (code 11) sets C; complement-carry (code 12) inverts C. Both clear H and N and return A. Complement (code 13) returns ~A and sets H and N. All three keep Z.
- R10: For every code, `wide_sum` = SP + sign-extended B, modulo 65536. Code 14 clears Z and N. It sets H when SP[3:0]+B[3:0] ≥ 16 and C when SP[7:0]+B ≥ 256, and returns A.
- R11: Code 15 returns A and passes `flags_in[7:4]` through unchanged.
- R12: `flag_q` resets to 0x00 and loads `flags_out` at a rising clock edge when `op_valid` is 1. It holds its value when `op_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Load `flags_out` into `flag_q` at the next edge |
| op_sel | input | 4 | Operation code, 0 to 15 |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand / signed offset |
| flags_in | input | 8 | Incoming flag byte |
| sp_in | input | 16 | Stack pointer |
| result | output | 8 | Byte result |
| wide_sum | output | 16 | SP plus sign-extended B |
| flags_out | output | 8 | New flag byte |
| flag_q | output | 8 | Registered flag byte |

## Verification
The hardest cases to reach are the decimal-adjust corners. These are where the low-nibble correction carries into the high nibble, and where a stale half-carry or carry appears with digit values that could never follow a real BCD add. The stimulus skips any preceding add. It drives every accumulator value against all sixteen upper flag combinations directly on `flags_in`, so each pairing of N, H and C with every digit pattern appears. The binary operations are swept over all operand pairs with both carry-in values. The stack-pointer add is swept over every offset against a spread of pointer values, including ones at the 16-bit wrap.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 8;
    localparam int WIDE_W = 16;
    localparam int NIB_W  = DATA_W / 2;

    // Flag positions inside the packed flag byte
    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_AND   = 4'd4,
        OP_XOR   = 4'd5,
        OP_OR    = 4'd6,
        OP_CMP   = 4'd7,
        OP_INC   = 4'd8,
        OP_DEC   = 4'd9,
        OP_DAA   = 4'd10,
        OP_SCF   = 4'd11,
        OP_CCF   = 4'd12,
        OP_CPL   = 4'd13,
        OP_SPOFS = 4'd14,
        OP_PASS  = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         half,
    output logic         carry
);
    localparam int NW = W / 2;

    logic [W:0]  full;
    logic [NW:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end
        res   = full[W-1:0];
        carry = full[W];
        half  = low[NW];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         half
);
    always_comb begin
        res  = a;
        half = 1'b0;
        unique case (op)
            OP_AND:  begin res = a & b; half = 1'b1; end
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_CPL:  begin res = ~a; half = 1'b1; end
            default: begin res = a; half = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         n_in,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int NW = W / 2;

    logic [W:0]   stage;
    logic [W-1:0] sub_fix;

    always_comb begin
        // correction after an addition
        stage = {1'b0, a};
        if (a[NW-1:0] > 4'd9 || h_in)
            stage = stage + (W+1)'(6);
        // correction after a subtraction
        sub_fix = a;
        if (h_in) sub_fix = sub_fix + W'(8'hFA);
        if (c_in) sub_fix = sub_fix + W'(8'hA0);

        if (n_in) begin
            res   = sub_fix;
            c_out = c_in;
        end else if (stage[W:NW] > 5'd9 || c_in) begin
            res   = stage[W-1:0] + W'(8'h60);
            c_out = 1'b1;
        end else begin
            res   = stage[W-1:0];
            c_out = 1'b0;
        end
    end
endmodule

// File: rtl/alu_spofs.sv
module alu_spofs
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int WW = WIDE_W
) (
    input  logic [WW-1:0] sp,
    input  logic [W-1:0]  ofs,
    output logic [WW-1:0] sum,
    output logic          half,
    output logic          carry
);
    localparam int NW = W / 2;

    logic [W:0]  low_byte;
    logic [NW:0] low_nib;

    always_comb begin
        sum      = sp + {{(WW-W){ofs[W-1]}}, ofs};
        low_byte = {1'b0, sp[W-1:0]} + {1'b0, ofs};
        low_nib  = {1'b0, sp[NW-1:0]} + {1'b0, ofs[NW-1:0]};
        carry    = low_byte[W];
        half     = low_nib[NW];
    end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int WW = WIDE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [7:0]    flags_in,
    input  logic [WW-1:0] sp_in,
    output logic [W-1:0]  result,
    output logic [WW-1:0] wide_sum,
    output logic [7:0]    flags_out,
    output logic [7:0]    flag_q
);
    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    logic fz, fn, fh, fc;
    assign fz = flags_in[FZ];
    assign fn = flags_in[FN];
    assign fh = flags_in[FH];
    assign fc = flags_in[FC];

    // adder/subtractor operand steering
    logic [W-1:0] as_b, as_res;
    logic         as_cin, as_sub, as_h, as_c;

    always_comb begin
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:         as_cin = fc;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC:         begin as_sub = 1'b1; as_cin = fc; end
            OP_INC:         begin as_b = '0; as_cin = 1'b1; end
            OP_DEC:         begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
            default:        ;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .res(as_res), .half(as_h), .carry(as_c)
    );

    logic [W-1:0] lg_res;
    logic         lg_h;
    alu_logic #(.W(W)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .res(lg_res), .half(lg_h)
    );

    logic [W-1:0] da_res;
    logic         da_c;
    alu_decadj #(.W(W)) u_decadj (
        .a(opnd_a), .n_in(fn), .h_in(fh), .c_in(fc),
        .res(da_res), .c_out(da_c)
    );

    logic so_h, so_c;
    alu_spofs #(.W(W), .WW(WW)) u_spofs (
        .sp(sp_in), .ofs(opnd_b), .sum(wide_sum), .half(so_h), .carry(so_c)
    );

    // result and flag selection
    logic nz, nn, nh, nc;

    always_comb begin
        result = opnd_a;
        nz = fz; nn = fn; nh = fh; nc = fc;
        unique case (op)
            OP_ADD, OP_ADC: begin
                result = as_res; nz = (as_res == '0); nn = 1'b0; nh = as_h; nc = as_c;
            end
            OP_SUB, OP_SBC: begin
                result = as_res; nz = (as_res == '0); nn = 1'b1; nh = as_h; nc = as_c;
            end
            OP_CMP: begin
                result = opnd_a; nz = (as_res == '0); nn = 1'b1; nh = as_h; nc = as_c;
            end
            OP_AND, OP_XOR, OP_OR: begin
                result = lg_res; nz = (lg_res == '0); nn = 1'b0; nh = lg_h; nc = 1'b0;
            end
            OP_INC: begin
                result = as_res; nz = (as_res == '0); nn = 1'b0; nh = as_h;
            end
            OP_DEC: begin
                result = as_res; nz = (as_res == '0); nn = 1'b1; nh = as_h;
            end
            OP_DAA: begin
                result = da_res; nz = (da_res == '0); nh = 1'b0; nc = da_c;
            end
            OP_SCF: begin nn = 1'b0; nh = 1'b0; nc = 1'b1; end
            OP_CCF: begin nn = 1'b0; nh = 1'b0; nc = ~fc; end
            OP_CPL: begin result = lg_res; nn = 1'b1; nh = lg_h; end
            OP_SPOFS: begin nz = 1'b0; nn = 1'b0; nh = so_h; nc = so_c; end
            OP_PASS: ;
        endcase
        flags_out = {nz, nn, nh, nc, 4'b0000};
    end

    // registered flag byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 8'h00;
        else if (op_valid) flag_q <= flags_out;
    end

    AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out[3:0] == 4'h0) && (flag_q[3:0] == 4'h0)); // R1

    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd8 || op_sel == 4'd9) |-> (flags_out[FC] == flags_in[FC])); // R6

    AST_SPOFS_ZN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd14) |-> (flags_out[FZ:FN] == 2'b00)); // R10

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd4 && op_sel <= 4'd6) |-> !flags_out[FC] && !flags_out[FN]); // R5

    AST_FLAGREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_q == $past(flags_out))); // R12

    AST_FLAGREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flag_q)); // R12
endmodule

// File: tb/byte_alu_core_tb_top.sv
`timescale 1ns/1ps
module byte_alu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [7:0]  opnd_a = '0, opnd_b = '0, flags_in = '0;
    logic [15:0] sp_in = '0;
    logic [7:0]  result, flags_out, flag_q;
    logic [15:0] wide_sum;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    byte_alu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in), .sp_in(sp_in),
        .result(result), .wide_sum(wide_sum), .flags_out(flags_out), .flag_q(flag_q)
    );

    function automatic int b2i(bit x);
        return x ? 1 : 0;
    endfunction

    // reference: returns {result, flag byte}
    function automatic logic [15:0] ref_model(int op, int a, int b, int f, int sp);
        int z, n, h, c, r, s, t;
        z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
        r = a;
        case (op)
            0, 1: begin
                t = (op == 1) ? c : 0;
                s = a + b + t;
                h = b2i(((a & 15) + (b & 15) + t) >= 16);
                c = b2i(s >= 256); r = s & 255; n = 0; z = b2i(r == 0);
            end
            2, 3, 7: begin
                t = (op == 3) ? c : 0;
                s = a - b - t;
                h = b2i(((a & 15) - (b & 15) - t) < 0);
                c = b2i(s < 0); r = s & 255; n = 1; z = b2i(r == 0);
                if (op == 7) r = a;
            end
            4: begin r = a & b; h = 1; c = 0; n = 0; z = b2i(r == 0); end
            5: begin r = a ^ b; h = 0; c = 0; n = 0; z = b2i(r == 0); end
            6: begin r = a | b; h = 0; c = 0; n = 0; z = b2i(r == 0); end
            8: begin r = (a + 1) & 255; h = b2i((a & 15) == 15); n = 0; z = b2i(r == 0); end
            9: begin r = (a + 255) & 255; h = b2i((a & 15) == 0); n = 1; z = b2i(r == 0); end
            10: begin
                if (n == 1) begin
                    s = a;
                    if (h == 1) s = s + 250;
                    if (c == 1) s = s + 160;
                    r = s & 255;
                end else begin
                    s = a;
                    if ((a & 15) > 9 || h == 1) s = s + 6;
                    if (((s & 'h1F0) > 'h90) || c == 1) begin s = s + 'h60; c = 1; end
                    else c = 0;
                    r = s & 255;
                end
                h = 0; z = b2i(r == 0);
            end
            11: begin c = 1; h = 0; n = 0; end
            12: begin c = 1 - c; h = 0; n = 0; end
            13: begin r = (~a) & 255; h = 1; n = 1; end
            14: begin
                z = 0; n = 0;
                h = b2i(((sp & 15) + (b & 15)) >= 16);
                c = b2i(((sp & 255) + (b & 255)) >= 256);
            end
            default: ;
        endcase
        return {r[7:0], z[0], n[0], h[0], c[0], 4'b0000};
    endfunction

    function automatic string req_name(int op, int f);
        case (op)
            0, 1:    return "R2";
            2, 3:    return "R3";
            7:       return "R4";
            4, 5, 6: return "R5";
            8, 9:    return "R6";
            10:      return ((f >> 6) & 1) != 0 ? "R8" : "R7";
            11, 12, 13: return "R9";
            14:      return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check8(string req, string what, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h (op=%0d a=%02h b=%02h f=%02h)",
                     req, what, got, exp, op_sel, opnd_a, opnd_b, flags_in);
        end
    endtask

    task automatic check16(string req, string what, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %04h expected %04h", req, what, got, exp);
        end
    endtask

    // apply one combinational vector and compare result and flags
    task automatic apply_vec(int op, int a, int b, int f, int sp);
        logic [15:0] e;
        op_sel = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        flags_in = f[7:0]; sp_in = sp[15:0];
        #1;
        e = ref_model(op, a, b, f, sp);
        check8(req_name(op, f), "result", result, e[15:8]);
        check8(req_name(op, f), "flags", flags_out, e[7:0]);
        if (flags_out[3:0] !== 4'h0) check8("R1", "flag low nibble", flags_out, e[7:0]);
    endtask

    initial begin
        // reset state (R12)
        repeat (2) @(posedge clk);
        #1 check8("R12", "flag_q at reset", flag_q, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        // binary operations: every operand pair, both carry-in values
        for (int op = 0; op < 8; op++)
            for (int cin = 0; cin < 2; cin++)
                for (int a = 0; a < 256; a++)
                    for (int b = 0; b < 256; b++)
                        apply_vec(op, a, b, ((a & 1) << 7) | ((b & 1) << 6) |
                                  (((a ^ b) & 2) << 4) | (cin << 4) | 'hA, 0);

        // unary operations: every A against every upper flag pattern, junk low nibble (R1)
        for (int op = 8; op < 14; op++)
            for (int fl = 0; fl < 16; fl++)
                for (int a = 0; a < 256; a++)
                    apply_vec(op, a, a ^ 'h5A, (fl << 4) | fl, 0);
        for (int fl = 0; fl < 16; fl++)
            for (int a = 0; a < 256; a += 5)
                apply_vec(15, a, 0, (fl << 4) | (15 - fl), 0);

        // stack-pointer offset add (R10), including wrap points
        for (int si = 0; si < 66; si++) begin
            int sp;
            sp = (si == 64) ? 'hFFFF : (si == 65) ? 'h00FF : ((si * 'h0A3D + 'h00F7) & 'hFFFF);
            for (int b = 0; b < 256; b++) begin
                int ofs;
                ofs = (b >= 128) ? b - 256 : b;
                apply_vec(14, b ^ 'h33, b, (si & 15) << 4, sp);
                check16("R10", "wide_sum", wide_sum, 16'((sp + ofs) & 'hFFFF));
            end
        end

        // flag register load and hold (R12)
        @(negedge clk);
        op_sel = 4'd0; opnd_a = 8'hFF; opnd_b = 8'h01; flags_in = 8'h00; op_valid = 1'b1;
        @(posedge clk); #1 check8("R12", "flag_q load", flag_q, 8'hB0);
        @(negedge clk);
        op_valid = 1'b0; opnd_a = 8'h01; opnd_b = 8'h01;
        @(posedge clk); #1 check8("R12", "flag_q hold", flag_q, 8'hB0);
        @(negedge clk);
        op_sel = 4'd11; flags_in = 8'hEF; op_valid = 1'b1;
        @(posedge clk); #1 check8("R12", "flag_q load scf", flag_q, 8'h90);
        @(negedge clk);
        op_sel = 4'd13; opnd_a = 8'h0F; flags_in = 8'h00; op_valid = 1'b1;
        @(posedge clk); #1 check8("R12", "flag_q load cpl", flag_q, 8'h60);
        @(negedge clk);
        op_valid = 1'b0; rst_n = 1'b0;
        #2 check8("R12", "flag_q async reset", flag_q, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(180000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule